// File: doc/BRIEF.md
# SPI-4.2 Packet Generator with Error Injection

This block is a stimulus source for a 16-bit SPI-4.2 style receive path. One start command describes a whole packet: a port address, a four-bit fault selector, a payload byte count and a seed byte. The generator then emits the packet on its own. It sends an opening payload control word, a one-word header, the payload words and a closing idle control word. It computes the four-bit diagonal parity (DIP4) for every control word, and it pulses `done` once the packet is out.

The fault selector adds deliberate deviations from the legal stream so that a receiver's checkers can be exercised. These include corrupt parity, a missing start or end marker, an abort termination and SOP set in the closing word. Two selector values are legal variants instead: a payload control word, or an idle word followed by a payload control word, placed after the header. A second command places one raw control word on the bus for a single cycle, with its parity computed and optionally inverted.

Top module: `pkt_err_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `tx_valid`, `tx_ctl`, `done` and `busy` are 0 until a command arrives.
- R2: `start` is taken only when `busy` is 0. A start sampled at clock edge k raises `busy` after edge k and puts the opening control word on the outputs after edge k+1. While `busy` is 1, `start` and `raw_send` are ignored. If both are high in an idle cycle, the packet wins and the raw word is dropped.
- R3: Control word layout: bit 15 is 1 for a payload control word and 0 for idle. Bits [14:13] carry the end status: 00 none, 01 abort, 10 end with 2 valid bytes, 11 end with 1 valid byte. Bit 12 is SOP, bits [11:4] are the port address and bits [3:0] are DIP4. `tx_ctl` is 1 on every control word. The opening word is a payload control word with end status 00, SOP 1 and the captured port in [11:4].
- R4: After the opening word comes one header data word: bit 15 is the header error flag and bits [14:0] hold `pay_len` zero-extended. The payload words follow, high byte first. The first byte equals `first_byte` and each later byte is one more, modulo 256.
- R5: The closing word is an idle control word with [11:4] zero. For an even byte count, including 0, its end status is 10. For an odd count, the last data word carries 00 in its low byte and the end status is 11.
- R6: DIP4 is computed as follows. Start an accumulator at 0 after every control word. For each data word, set acc = rotl1(acc) XOR word. For a control word, take x = rotl1(acc) XOR {word[15:4], 4'hF}. DIP4 is x[15:12]^x[11:8]^x[7:4]^x[3:0].
- R7: `done` is high for exactly one cycle: the cycle right after the closing control word is shown. In that cycle `tx_valid` and `busy` are 0.
- R8: Selector 1 sets the header error flag and inverts the closing DIP4. Selector 9 inverts the closing DIP4 only.
- R9: Selector 2 clears SOP in the opening word. Selector 3 gives the closing word end status 00.
- R10: Selector 4 places a payload control word (bit 15 = 1, end status 00, SOP 0, captured port) right after the header. Selector 5 places an idle control word with all fields 0 and then that payload control word there.
- R11: Selector 6 sets SOP in the closing word and keeps its normal end status. Selector 7 sets SOP and end status 01 in the closing word.
- R12: Selector 8 closes with end status 01 and sets the header error flag. Selectors 10 to 15 behave as selector 0.
- R13: A `raw_send` sampled while idle, with no start, drives {raw_word[15:4], DIP4} with `tx_ctl` = 1 for exactly one cycle after that edge. The DIP4 is bit-inverted when `raw_inv` is 1, and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Packet command strobe |
| port_addr | input | 8 | Port address for the packet |
| err_code | input | 4 | Fault selector |
| pay_len | input | LEN_W (10) | Payload byte count, also the header length field |
| first_byte | input | 8 | Value of the first payload byte |
| raw_send | input | 1 | Raw control word strobe |
| raw_word | input | 16 | Raw control word; bits [3:0] are replaced |
| raw_inv | input | 1 | Invert the parity of the raw word |
| tx_data | output | 16 | Bus word |
| tx_ctl | output | 1 | Word is a control word |
| tx_valid | output | 1 | Bus word is present |
| done | output | 1 | One-cycle end-of-packet pulse |
| busy | output | 1 | Packet in progress |

## Verification
A parity accumulator that is not cleared, or that is not stepped on a data word, shows at once in the DIP4 nibble of the next control word. It also carries over into the raw word that follows a packet. A byte counter that is off by one shows as a wrong byte within a word, and then as a wrong end status (10 versus 11) in the closing word. A sequencer stuck in a state or skipping one gives the wrong number of words before `done`, or a `done` that does not follow the closing word directly. The same fault also lets `start` or `raw_send` through while `busy` is 1, which appears on the bus a cycle later.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_SOP     = 3'd1,
    S_HDR     = 3'd2,
    S_MIDIDLE = 3'd3,
    S_MIDCW   = 3'd4,
    S_DATA    = 3'd5,
    S_EOP     = 3'd6,
    S_FIN     = 3'd7
  } gen_st_e;

  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_ABORT = 2'b01,
    END_TWO   = 2'b10,
    END_ONE   = 2'b11
  } end_stat_e;

  localparam logic [3:0] SEL_CLEAN    = 4'd0;
  localparam logic [3:0] SEL_BADPAR_E = 4'd1;
  localparam logic [3:0] SEL_NOSOP    = 4'd2;
  localparam logic [3:0] SEL_NOEOP    = 4'd3;
  localparam logic [3:0] SEL_MIDCW    = 4'd4;
  localparam logic [3:0] SEL_MIDIDLE  = 4'd5;
  localparam logic [3:0] SEL_SOPEND   = 4'd6;
  localparam logic [3:0] SEL_SOPABT   = 4'd7;
  localparam logic [3:0] SEL_ABORT    = 4'd8;
  localparam logic [3:0] SEL_BADPAR   = 4'd9;
  localparam logic [3:0] SEL_LAST     = 4'd9;

  function automatic logic [15:0] rotl1(input logic [15:0] v);
    return {v[14:0], v[15]};
  endfunction

  function automatic logic [3:0] fold4(input logic [15:0] v);
    return v[15:12] ^ v[11:8] ^ v[7:4] ^ v[3:0];
  endfunction

  // Control word with parity field preset to ones.
  function automatic logic [15:0] mk_cw(input logic pctl, input logic [1:0] stat,
                                        input logic sop, input logic [7:0] adr);
    return {pctl, stat, sop, adr, 4'hF};
  endfunction

endpackage

// File: rtl/pktgen_dip4.sv
module pktgen_dip4
  import pktgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_en,
  input  logic        cw_en,
  input  logic [15:0] word,
  input  logic        inv,
  output logic [3:0]  dip
);

  logic [15:0] acc_q;
  logic [15:0] acc_d;
  logic        acc_ce;
  logic [15:0] mix;

  assign mix = rotl1(acc_q) ^ {word[15:4], 4'hF};
  assign dip = fold4(mix) ^ {4{inv}};

  assign acc_ce = data_en | cw_en;

  always_comb begin
    if (cw_en) acc_d = '0;
    else       acc_d = rotl1(acc_q) ^ word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  // R6
  dip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_en && cw_en));

endmodule

// File: rtl/pktgen_bytes.sv
module pktgen_bytes #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] len_in,
  input  logic [7:0]       first_in,
  output logic [15:0]      word,
  output logic             more,
  output logic             last,
  output logic             odd
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic [7:0]       cur_q, cur_d;
  logic             odd_q, odd_d;
  logic             ce;

  assign ce = load | step;

  always_comb begin
    rem_d = rem_q;
    cur_d = cur_q;
    odd_d = odd_q;
    if (load) begin
      rem_d = len_in;
      cur_d = first_in;
      odd_d = len_in[0];
    end else if (rem_q >= TWO) begin
      rem_d = rem_q - TWO;
      cur_d = cur_q + 8'd2;
    end else begin
      rem_d = '0;
      cur_d = cur_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cur_q <= '0;
      odd_q <= 1'b0;
    end else if (ce) begin
      rem_q <= rem_d;
      cur_q <= cur_d;
      odd_q <= odd_d;
    end
  end

  assign word = (rem_q == ONE) ? {cur_q, 8'h00} : {cur_q, cur_q + 8'd1};
  assign more = (rem_q != '0);
  assign last = (rem_q <= TWO);
  assign odd  = odd_q;

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> more);

endmodule

// File: rtl/pktgen_seq.sv
module pktgen_seq
  import pktgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [3:0] sel,
  input  logic       more,
  input  logic       last,
  output gen_st_e    st
);

  gen_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:    if (go) st_d = S_SOP;
      S_SOP:     st_d = S_HDR;
      S_HDR: begin
        if (sel == SEL_MIDCW)        st_d = S_MIDCW;
        else if (sel == SEL_MIDIDLE) st_d = S_MIDIDLE;
        else if (more)               st_d = S_DATA;
        else                         st_d = S_EOP;
      end
      S_MIDIDLE: st_d = S_MIDCW;
      S_MIDCW:   st_d = more ? S_DATA : S_EOP;
      S_DATA:    st_d = last ? S_EOP : S_DATA;
      S_EOP:     st_d = S_FIN;
      S_FIN:     st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R7
  fin_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FIN) |=> (st_q == S_IDLE));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !go) |=> (st_q == S_IDLE));

endmodule

// File: rtl/pkt_err_gen.sv
module pkt_err_gen
  import pktgen_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       port_addr,
  input  logic [3:0]       err_code,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [7:0]       first_byte,
  input  logic             raw_send,
  input  logic [15:0]      raw_word,
  input  logic             raw_inv,
  output logic [15:0]      tx_data,
  output logic             tx_ctl,
  output logic             tx_valid,
  output logic             done,
  output logic             busy
);

  gen_st_e          st;
  logic             idle;
  logic             go;
  logic             raw_go;
  logic [3:0]       sel_in;
  logic [3:0]       sel_q;
  logic [7:0]       port_q;
  logic [LEN_W-1:0] len_q;

  logic [15:0] b_word;
  logic        b_more, b_last, b_odd;
  logic        step;

  logic [15:0] cw_w;
  logic [15:0] dword;
  logic        is_cw, is_data, inv;
  logic [3:0]  dip;
  logic        hdr_err;
  logic        sop_close;
  end_stat_e   end_sel;

  logic [15:0] data_d;

  assign idle   = (st == S_IDLE);
  assign go     = start && idle;
  assign raw_go = raw_send && idle && !start;
  assign sel_in = (err_code > SEL_LAST) ? SEL_CLEAN : err_code;

  // Command capture, enabled only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      port_q <= '0;
      len_q  <= '0;
    end else if (go) begin
      sel_q  <= sel_in;
      port_q <= port_addr;
      len_q  <= pay_len;
    end
  end

  pktgen_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .sel   (sel_q),
    .more  (b_more),
    .last  (b_last),
    .st    (st)
  );

  assign step = (st == S_DATA);

  pktgen_bytes #(.LEN_W(LEN_W)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .step     (step),
    .len_in   (pay_len),
    .first_in (first_byte),
    .word     (b_word),
    .more     (b_more),
    .last     (b_last),
    .odd      (b_odd)
  );

  assign hdr_err   = (sel_q == SEL_BADPAR_E) || (sel_q == SEL_ABORT);
  assign sop_close = (sel_q == SEL_SOPEND) || (sel_q == SEL_SOPABT);

  always_comb begin
    if (sel_q == SEL_NOEOP)
      end_sel = END_NONE;
    else if (sel_q == SEL_SOPABT || sel_q == SEL_ABORT)
      end_sel = END_ABORT;
    else if (b_odd)
      end_sel = END_ONE;
    else
      end_sel = END_TWO;
  end

  // Word selection for the cycle; the output register loads it.
  always_comb begin
    cw_w    = '0;
    dword   = '0;
    is_cw   = 1'b0;
    is_data = 1'b0;
    inv     = 1'b0;
    case (st)
      S_IDLE: begin
        if (raw_go) begin
          cw_w  = raw_word;
          inv   = raw_inv;
          is_cw = 1'b1;
        end
      end
      S_SOP: begin
        cw_w  = mk_cw(1'b1, END_NONE, sel_q != SEL_NOSOP, port_q);
        is_cw = 1'b1;
      end
      S_HDR: begin
        dword   = {hdr_err, 15'(len_q)};
        is_data = 1'b1;
      end
      S_MIDIDLE: begin
        cw_w  = mk_cw(1'b0, END_NONE, 1'b0, 8'h00);
        is_cw = 1'b1;
      end
      S_MIDCW: begin
        cw_w  = mk_cw(1'b1, END_NONE, 1'b0, port_q);
        is_cw = 1'b1;
      end
      S_DATA: begin
        dword   = b_word;
        is_data = 1'b1;
      end
      S_EOP: begin
        cw_w  = mk_cw(1'b0, end_sel, sop_close, 8'h00);
        inv   = (sel_q == SEL_BADPAR_E) || (sel_q == SEL_BADPAR);
        is_cw = 1'b1;
      end
      default: ;
    endcase
  end

  pktgen_dip4 u_dip (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_en (is_data),
    .cw_en   (is_cw),
    .word    (is_cw ? cw_w : dword),
    .inv     (inv),
    .dip     (dip)
  );

  assign data_d = is_cw ? {cw_w[15:4], dip} : dword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_ctl   <= 1'b0;
      tx_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      tx_data  <= data_d;
      tx_ctl   <= is_cw;
      tx_valid <= is_cw | is_data;
      done     <= (st == S_FIN);
    end
  end

  assign busy = !idle;

  // R3
  ctl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl |-> tx_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_cw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_valid && !busy && $past(tx_ctl)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R13
  raw_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_send && !start && !busy) |=> (tx_valid && tx_ctl && !busy));

endmodule

// File: tb/tb_pkt_err_gen.sv
module tb_pkt_err_gen;

  localparam int LEN_W = 10;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [7:0]       port_addr;
  logic [3:0]       err_code;
  logic [LEN_W-1:0] pay_len;
  logic [7:0]       first_byte;
  logic             raw_send;
  logic [15:0]      raw_word;
  logic             raw_inv;
  logic [15:0]      tx_data;
  logic             tx_ctl;
  logic             tx_valid;
  logic             done;
  logic             busy;

  int total = 0;
  int bad   = 0;

  logic [15:0] ew [64];
  logic        ec [64];
  int          en;
  logic [15:0] acc;

  pkt_err_gen #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .port_addr(port_addr),
    .err_code(err_code), .pay_len(pay_len), .first_byte(first_byte),
    .raw_send(raw_send), .raw_word(raw_word), .raw_inv(raw_inv),
    .tx_data(tx_data), .tx_ctl(tx_ctl), .tx_valid(tx_valid),
    .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push_data(input logic [15:0] w);
    acc    = {acc[14:0], acc[15]} ^ w;
    ew[en] = w;
    ec[en] = 1'b0;
    en++;
  endtask

  task automatic push_cw(input logic [15:0] w, input logic iv);
    logic [15:0] x;
    logic [3:0]  d;
    x = {acc[14:0], acc[15]} ^ {w[15:4], 4'hF};
    d = x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
    if (iv) d = ~d;
    ew[en] = {w[15:4], d};
    ec[en] = 1'b1;
    en++;
    acc = '0;
  endtask

  // Expected word stream built from the requirements.
  task automatic build(input logic [7:0] prt, input int code, input int len,
                       input logic [7:0] fb);
    int         c;
    logic [7:0] b;
    logic [1:0] es;
    c   = (code > 9) ? 0 : code;
    acc = '0;
    en  = 0;
    push_cw({1'b1, 2'b00, (c != 2), prt, 4'h0}, 1'b0);
    push_data({(c == 1 || c == 8), 15'(len)});
    if (c == 4) push_cw({1'b1, 2'b00, 1'b0, prt, 4'h0}, 1'b0);
    if (c == 5) begin
      push_cw(16'h0000, 1'b0);
      push_cw({1'b1, 2'b00, 1'b0, prt, 4'h0}, 1'b0);
    end
    b = fb;
    for (int i = 0; i < len; i += 2) begin
      if (len - i >= 2) begin
        push_data({b, b + 8'd1});
        b = b + 8'd2;
      end else begin
        push_data({b, 8'h00});
      end
    end
    if (c == 3)                es = 2'b00;
    else if (c == 7 || c == 8) es = 2'b01;
    else if (len % 2 == 1)     es = 2'b11;
    else                       es = 2'b10;
    push_cw({1'b0, es, (c == 6 || c == 7), 8'h00, 4'h0}, (c == 1 || c == 9));
  endtask

  task automatic run_pkt(input logic [7:0] prt, input int code, input int len,
                         input logic [7:0] fb, input bit poke, input bit both,
                         input string req);
    int idx;
    bit got_done;
    bit prev_v;
    build(prt, code, len, fb);
    @(negedge clk);
    start      = 1'b1;
    port_addr  = prt;
    err_code   = 4'(code);
    pay_len    = LEN_W'(len);
    first_byte = fb;
    if (both) begin
      raw_send = 1'b1;
      raw_word = 16'hBEEF;
    end
    @(negedge clk);
    start    = 1'b0;
    raw_send = 1'b0;
    // R2: accepted, nothing on the bus yet (raw word dropped if both)
    chk(busy && !tx_valid, "R2", {busy, tx_valid}, 2'b10);
    idx      = 0;
    got_done = 1'b0;
    prev_v   = 1'b0;
    for (int cyc = 0; cyc < 200 && !got_done; cyc++) begin
      @(negedge clk);
      if (cyc == 0) chk(tx_valid && tx_ctl, "R2", {tx_valid, tx_ctl}, 2'b11);
      if (tx_valid) begin
        if (idx < en)
          chk(tx_data == ew[idx] && tx_ctl == ec[idx], req,
              {15'(idx), tx_ctl, tx_data}, {15'(idx), ec[idx], ew[idx]});
        else
          chk(1'b0, req, 32'(idx), 32'(en));
        idx++;
      end
      if (done) begin
        got_done = 1'b1;
        chk(idx == en, "R7", 32'(idx), 32'(en));
        chk(prev_v && !tx_valid && !busy, "R7", {prev_v, tx_valid, busy}, 3'b100);
      end
      prev_v = tx_valid;
      if (poke && busy) begin
        start     = 1'b1;
        err_code  = 4'd2;
        port_addr = 8'h55;
        pay_len   = LEN_W'(3);
        raw_send  = 1'b1;
        raw_word  = 16'h1234;
      end else begin
        start    = 1'b0;
        raw_send = 1'b0;
      end
    end
    chk(got_done, "R7", 32'(got_done), 32'd1);
    @(negedge clk);
    chk(!done, "R7", 32'(done), 32'd0);
    for (int k = 0; k < 3; k++) begin
      // R2: nothing launched by ignored commands
      chk(!tx_valid && !busy, "R2", {tx_valid, busy}, 2'b00);
      @(negedge clk);
    end
  endtask

  task automatic run_raw(input logic [15:0] w, input logic iv);
    acc = '0;
    en  = 0;
    push_cw(w, iv);
    @(negedge clk);
    raw_send = 1'b1;
    raw_word = w;
    raw_inv  = iv;
    @(negedge clk);
    raw_send = 1'b0;
    raw_inv  = 1'b0;
    chk(tx_valid && tx_ctl && tx_data == ew[0] && !busy, "R13",
        {tx_valid, tx_ctl, busy, tx_data}, {3'b110, ew[0]});
    @(negedge clk);
    chk(!tx_valid && !done, "R13", {tx_valid, done}, 2'b00);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!tx_valid && !tx_ctl && !done && !busy, "R1",
        {tx_valid, tx_ctl, done, busy}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_valid && !tx_ctl && !done && !busy, "R1",
        {tx_valid, tx_ctl, done, busy}, 4'b0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    port_addr  = '0;
    err_code   = '0;
    pay_len    = '0;
    first_byte = '0;
    raw_send   = 1'b0;
    raw_word   = '0;
    raw_inv    = 1'b0;
    test_reset();
    run_pkt(8'hA3, 0, 6, 8'h10, 1'b0, 1'b0, "R4");
    run_pkt(8'h3C, 0, 5, 8'hFE, 1'b0, 1'b0, "R5");
    run_pkt(8'h01, 0, 0, 8'h00, 1'b0, 1'b0, "R5");
    run_pkt(8'h7E, 0, 9, 8'hF9, 1'b0, 1'b0, "R6");
    run_pkt(8'h11, 1, 4, 8'h20, 1'b0, 1'b0, "R8");
    run_pkt(8'h22, 9, 3, 8'h30, 1'b0, 1'b0, "R8");
    run_pkt(8'h33, 2, 4, 8'h40, 1'b0, 1'b0, "R9");
    run_pkt(8'h44, 3, 3, 8'h50, 1'b0, 1'b0, "R9");
    run_pkt(8'h55, 4, 6, 8'h60, 1'b0, 1'b0, "R10");
    run_pkt(8'h66, 5, 5, 8'h70, 1'b0, 1'b0, "R10");
    run_pkt(8'h77, 4, 0, 8'h00, 1'b0, 1'b0, "R10");
    run_pkt(8'h88, 6, 4, 8'h80, 1'b0, 1'b0, "R11");
    run_pkt(8'h99, 7, 3, 8'h90, 1'b0, 1'b0, "R11");
    run_pkt(8'hAA, 8, 4, 8'hA0, 1'b0, 1'b0, "R12");
    run_pkt(8'hBB, 12, 4, 8'hB0, 1'b0, 1'b0, "R12");
    run_pkt(8'hCC, 0, 7, 8'hC0, 1'b1, 1'b0, "R2");
    run_pkt(8'hDD, 0, 2, 8'hD0, 1'b0, 1'b1, "R2");
    run_raw(16'hA5C3, 1'b0);
    run_raw(16'hA5C3, 1'b1);
    run_raw(16'h0000, 1'b0);
    run_pkt(8'hEE, 1, 1, 8'hFF, 1'b0, 1'b0, "R3");
    run_raw(16'h6F0A, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule